// File: doc/BRIEF.md
# Channel Loopback and Transmit Alarm Controller

This block holds the mode control byte for one channel of a DS3/E3 framer and drives the logic that hangs off it. A processor reads and writes the byte through a plain strobe port. Two loopback bits steer the encoded bipolar rails. The line loopback sends the received rails, taken before line decoding, straight back out as the transmit rails, code violations included. The source loopback feeds the encoded transmit rails into the receive decoder input, and the line output carries on as before. Both loopbacks switch rails only. They do not touch data.

Two alarm request bits are decoded into a single transmit alarm command, and the decoding depends on the mode. In DS3 mode the two bits form a four-way code. In E3 mode each bit makes its own request, and AIS has priority. The block also outputs the mode enable and the framing variant select.

Switching a loopback moves internal circuits between clocks. For this reason, any accepted write that changes a loopback bit starts a fixed hold-off window, and `busy_o` is high for its whole length. An access made inside the window is reported on `acc_err_o`. A write made inside the window is dropped.

Top module: `chan_mode_ctl`

## Requirements
- R1: After reset, `rdata_o` is 0x00, `busy_o` and `acc_err_o` are low, `alarm_sel_o` is 0, `tx_line_o` equals `tx_enc_i`, and `dec_in_o` equals `rx_line_i`.
- R2: A write accepted at a clock edge is visible on `rdata_o` after that edge. Bit 7 is line loopback, bit 6 is source loopback, bits 5 and 4 are alarm requests a1 and a0, bit 1 is E3 mode, and bit 0 is the framing select. Bits 3 and 2 always read 0, and writes to them have no effect.
- R3: In DS3 mode (bit 1 = 0), `alarm_sel_o` equals {a1,a0}. The codes are 0 none, 1 yellow (X-bits low), 2 idle code, 3 AIS.
- R4: In E3 mode (bit 1 = 1), `alarm_sel_o` is 3 (AIS) whenever a0 = 1. It is 1 (yellow) when only a1 = 1, and 0 otherwise. Code 2 never appears in E3 mode.
- R5: With bit 7 set, `tx_line_o` follows `rx_line_i` bit for bit. With bit 7 clear, it follows `tx_enc_i`. Bit 7 alone never changes `dec_in_o`.
- R6: With bit 6 set, `dec_in_o` follows `tx_enc_i`. With bit 6 clear, it follows `rx_line_i`. Bit 6 alone never changes `tx_line_o`.
- R7: With both loopback bits set, `tx_line_o` carries `rx_line_i` and `dec_in_o` carries `tx_enc_i` at the same time.
- R8: An accepted write that changes bit 7 or bit 6 raises `busy_o` from the next cycle. `busy_o` then stays high for exactly HOLD_CYC cycles (20 by default). An accepted write that leaves both loopback bits unchanged does not raise `busy_o`.
- R9: A write made while `busy_o` is high is discarded: `rdata_o` stays unchanged.
- R10: A read or write strobe made while `busy_o` is high raises `acc_err_o` for the following cycle only. Strobes made while idle never raise it.
- R11: `e3_mode_o` and `frm_sel_o` always equal register bits 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (slowest channel clock) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Register contents |
| busy_o | output | 1 | Hold-off window active |
| acc_err_o | output | 1 | Access made during hold-off (one-cycle pulse) |
| rx_line_i | input | RAIL_W | Received bipolar rails before decoding |
| tx_enc_i | input | RAIL_W | Encoded transmit rails from the line encoder |
| tx_line_o | output | RAIL_W | Rails sent to the line |
| dec_in_o | output | RAIL_W | Rails fed to the receive decoder |
| alarm_sel_o | output | 2 | Transmit alarm command (0 none, 1 yellow, 2 idle, 3 AIS) |
| e3_mode_o | output | 1 | E3 mode enable |
| frm_sel_o | output | 1 | Framing variant select |

## Verification
A corrupted register bit shows up on the very next read, and the loopback mux and alarm decoder give it away at once, because both are combinational on the stored byte. A hold-off counter loaded wrong or decremented wrong shows up as `busy_o` dropping one or more cycles early or late, so the bench counts the window cycle by cycle after each loopback change. A discard or error path that is broken shows up within one cycle, either as a read-back value that moved or as a missing or stray `acc_err_o` pulse.

// File: rtl/chan_mode_pkg.sv
package chan_mode_pkg;
  localparam int REG_W        = 8;
  localparam int LB_LINE_BIT  = 7;
  localparam int LB_SRC_BIT   = 6;
  localparam int ALM1_BIT     = 5;
  localparam int ALM0_BIT     = 4;
  localparam int E3_BIT       = 1;
  localparam int FRM_BIT      = 0;
  localparam logic [REG_W-1:0] WR_MASK = 8'hF3;

  typedef enum logic [1:0] {
    ALM_NONE   = 2'd0,
    ALM_YELLOW = 2'd1,
    ALM_IDLE   = 2'd2,
    ALM_AIS    = 2'd3
  } alarm_e;
endpackage

// File: rtl/chan_mode_reg.sv
module chan_mode_reg
  import chan_mode_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             busy_i,
  output logic [REG_W-1:0] reg_o,
  output logic             lb_chg_o
);
  logic [REG_W-1:0] reg_q;
  logic             wr_ok;

  assign wr_ok    = wr_en_i && !busy_i;
  assign lb_chg_o = wr_ok &&
                    (wdata_i[LB_LINE_BIT:LB_SRC_BIT] != reg_q[LB_LINE_BIT:LB_SRC_BIT]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    reg_q <= '0;
    else if (wr_ok) reg_q <= wdata_i & WR_MASK;
  end

  assign reg_o = reg_q;
endmodule

// File: rtl/chan_holdoff.sv
module chan_holdoff #(
  parameter int HOLD_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic access_i,
  output logic busy_o,
  output logic acc_err_o
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic             err_q;

  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (start_i)     cnt_q <= CNT_LOAD;
      else if (busy_o) cnt_q <= cnt_q - 1'b1;
      err_q <= access_i && busy_o;
    end
  end

  assign acc_err_o = err_q;
endmodule

// File: rtl/chan_alarm_dec.sv
module chan_alarm_dec
  import chan_mode_pkg::*;
(
  input  logic       e3_i,
  input  logic [1:0] alm_i,
  output alarm_e     alarm_o
);
  always_comb begin
    if (!e3_i) begin
      alarm_o = alarm_e'(alm_i);
    end else if (alm_i[0]) begin
      alarm_o = ALM_AIS;  // AIS outranks yellow in E3
    end else if (alm_i[1]) begin
      alarm_o = ALM_YELLOW;
    end else begin
      alarm_o = ALM_NONE;
    end
  end
endmodule

// File: rtl/chan_loop_mux.sv
module chan_loop_mux #(
  parameter int RAIL_W = 2
) (
  input  logic              line_lb_i,
  input  logic              src_lb_i,
  input  logic [RAIL_W-1:0] rx_line_i,
  input  logic [RAIL_W-1:0] tx_enc_i,
  output logic [RAIL_W-1:0] tx_line_o,
  output logic [RAIL_W-1:0] dec_in_o
);
  for (genvar g = 0; g < RAIL_W; g++) begin : g_rail
    assign tx_line_o[g] = line_lb_i ? rx_line_i[g] : tx_enc_i[g];
    assign dec_in_o[g]  = src_lb_i  ? tx_enc_i[g]  : rx_line_i[g];
  end
endmodule

// File: rtl/chan_mode_ctl.sv
module chan_mode_ctl
  import chan_mode_pkg::*;
#(
  parameter int HOLD_CYC = 20,
  parameter int RAIL_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              busy_o,
  output logic              acc_err_o,
  input  logic [RAIL_W-1:0] rx_line_i,
  input  logic [RAIL_W-1:0] tx_enc_i,
  output logic [RAIL_W-1:0] tx_line_o,
  output logic [RAIL_W-1:0] dec_in_o,
  output logic [1:0]        alarm_sel_o,
  output logic              e3_mode_o,
  output logic              frm_sel_o
);
  logic [REG_W-1:0] ctl;
  logic             lb_chg;
  logic             busy;
  alarm_e           alarm;

  chan_mode_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .busy_i  (busy),
    .reg_o   (ctl),
    .lb_chg_o(lb_chg)
  );

  chan_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (lb_chg),
    .access_i (wr_en_i || rd_en_i),
    .busy_o   (busy),
    .acc_err_o(acc_err_o)
  );

  chan_alarm_dec u_alm (
    .e3_i   (ctl[E3_BIT]),
    .alm_i  ({ctl[ALM1_BIT], ctl[ALM0_BIT]}),
    .alarm_o(alarm)
  );

  chan_loop_mux #(.RAIL_W(RAIL_W)) u_mux (
    .line_lb_i(ctl[LB_LINE_BIT]),
    .src_lb_i (ctl[LB_SRC_BIT]),
    .rx_line_i(rx_line_i),
    .tx_enc_i (tx_enc_i),
    .tx_line_o(tx_line_o),
    .dec_in_o (dec_in_o)
  );

  assign rdata_o     = ctl;
  assign busy_o      = busy;
  assign alarm_sel_o = alarm;
  assign e3_mode_o   = ctl[E3_BIT];
  assign frm_sel_o   = ctl[FRM_BIT];
endmodule

// File: rtl/chan_mode_ctl_chk.sv
module chan_mode_ctl_chk #(
  parameter int RAIL_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic              busy_o,
  input logic              acc_err_o,
  input logic [RAIL_W-1:0] rx_line_i,
  input logic [RAIL_W-1:0] tx_enc_i,
  input logic [RAIL_W-1:0] tx_line_o,
  input logic [RAIL_W-1:0] dec_in_o,
  input logic [1:0]        alarm_sel_o
);
  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[3:2] == 2'b00);

  a_r4_e3_ais_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[1] && rdata_o[4]) |-> alarm_sel_o == 2'd3);

  a_r5_line_lb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[7] |-> tx_line_o == rx_line_i);

  a_r6_src_lb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[6] |-> dec_in_o == tx_enc_i);

  a_r8_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !busy_o && (wdata_i[7:6] != rdata_o[7:6])) |=> busy_o);

  a_r9_discard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && busy_o) |=> $stable(rdata_o));

  a_r10_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_en_i || rd_en_i) && busy_o) |=> acc_err_o);

  a_r10_no_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((wr_en_i || rd_en_i) && busy_o) |=> !acc_err_o);
endmodule

bind chan_mode_ctl chan_mode_ctl_chk #(.RAIL_W(RAIL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .busy_o     (busy_o),
  .acc_err_o  (acc_err_o),
  .rx_line_i  (rx_line_i),
  .tx_enc_i   (tx_enc_i),
  .tx_line_o  (tx_line_o),
  .dec_in_o   (dec_in_o),
  .alarm_sel_o(alarm_sel_o)
);

// File: tb/chan_mode_ctl_test.sv
module chan_mode_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 20;
  localparam int RW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          busy, acc_err, e3, frm;
  logic [RW-1:0] rx_line = '0, tx_enc = '0, tx_line, dec_in;
  logic [1:0]    alarm;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_mode_ctl #(.HOLD_CYC(HOLD), .RAIL_W(RW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy), .acc_err_o(acc_err),
    .rx_line_i(rx_line), .tx_enc_i(tx_enc), .tx_line_o(tx_line),
    .dec_in_o(dec_in), .alarm_sel_o(alarm), .e3_mode_o(e3), .frm_sel_o(frm)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_alarm(input logic [7:0] v);
    if (!v[1]) return int'({v[5], v[4]});
    if (v[4]) return 3;
    if (v[5]) return 1;
    return 0;
  endfunction

  task automatic do_write(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wdata = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic check_mux(input logic [7:0] v);
    for (int p = 0; p < 4; p++) begin
      rx_line = RW'(p);
      tx_enc  = RW'(3 - p);
      #1;
      if (v[7] && v[6])
        chk(tx_line == rx_line && dec_in == tx_enc, "R7", {tx_line, dec_in}, {rx_line, tx_enc});
      chk(tx_line == (v[7] ? rx_line : tx_enc), "R5", tx_line, v[7] ? rx_line : tx_enc);
      chk(dec_in == (v[6] ? tx_enc : rx_line), "R6", dec_in, v[6] ? tx_enc : rx_line);
    end
  endtask

  initial begin
    logic [7:0] cur;
    #(CLK_PERIOD * 3 + 2);
    chk(rdata == 8'h00, "R1 rdata", rdata, 0);
    chk(!busy && !acc_err, "R1 busy/err", {busy, acc_err}, 0);
    chk(alarm == 2'd0, "R1 alarm", alarm, 0);
    rx_line = 2'b01; tx_enc = 2'b10; #1;
    chk(tx_line == tx_enc && dec_in == rx_line, "R1 mux", {tx_line, dec_in}, {tx_enc, rx_line});
    rst_n = 1'b1;
    cur = 8'h00;

    for (int v = 0; v < 256; v++) begin
      logic [7:0] w;
      w = 8'(v);
      wait_idle();
      do_write(w);
      if (w[7:6] != cur[7:6]) begin
        for (int i = 1; i <= HOLD; i++) begin
          chk(busy, "R8 busy held", busy, 1);
          @(negedge clk);
        end
        chk(!busy, "R8 busy end", busy, 0);
      end else begin
        chk(!busy, "R8 no busy", busy, 0);
      end
      cur = w & 8'hF3;
      chk(rdata == cur, "R2 readback", rdata, cur);
      chk(int'(alarm) == exp_alarm(w), w[1] ? "R4 e3 alarm" : "R3 ds3 alarm",
          alarm, exp_alarm(w));
      chk(e3 == w[1] && frm == w[0], "R11 mode out", {e3, frm}, {w[1], w[0]});
      chk(!acc_err, "R10 no err idle", acc_err, 0);
      if (v[1:0] == 2'b00 || v[5:4] == 2'b11) check_mux(w);
    end

    // write during hold-off: discarded and flagged
    wait_idle();
    do_write(8'h00);
    cur = 8'h00;
    chk(busy, "R8 busy after change", busy, 1);
    @(negedge clk); wr_en = 1'b1; wdata = 8'h33;
    @(negedge clk); wr_en = 1'b0;
    chk(acc_err, "R10 err on write", acc_err, 1);
    chk(rdata == cur, "R9 discard", rdata, cur);
    @(negedge clk);
    chk(!acc_err, "R10 err one cycle", acc_err, 0);
    rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk(acc_err, "R10 err on read", acc_err, 1);
    wait_idle();
    rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk(!acc_err, "R10 read idle", acc_err, 0);
    chk(rdata == cur, "R9 still old", rdata, cur);
    // reserved bits only: no busy, reads zero
    do_write(8'h0C);
    chk(rdata == 8'h00 && !busy, "R2 reserved ignored", {rdata, busy}, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule